// File: doc/BRIEF.md
# Register-Programmed Pulse-Width Modulator

This block produces one pulse-width modulated output whose shape is set by a single 32-bit configuration word. Software writes that word through a one-cycle write strobe. A 13-bit divisor field slows the clock: one tick is issued every divisor+1 clocks. An 8-bit period counter advances once per tick, so every period is 256 ticks long. The 8-bit duty field sets how many of those ticks drive the output high.

A separate full-duty bit holds the output high for the whole period, whatever the duty field says. An enable bit starts and stops the waveform. Both disabling and rewriting the word act at once. The running period is abandoned, and the next one starts from zero.

Top module: `pwm_gen`

## Requirements
- R1: Configuration word layout: divisor in bits [12:0], duty in bits [23:16], full-duty flag in bit 24 and enable in bit 31. Bits [15:13] and [30:25] have no effect on the output.
- R2: While enabled, the prescaler issues one tick every divisor+1 clocks, so one output period lasts 256*(divisor+1) clocks. A divisor of 0 ticks on every clock.
- R3: While enabled with the full-duty flag clear, the output is 1 exactly while the period counter is below the duty value. Over each period it is high for duty*(divisor+1) clocks.
- R4: A duty value of 0 with the full-duty flag clear keeps the output at 0 for as long as that setting holds.
- R5: While enabled with the full-duty flag set, the output is 1 on every clock and the duty field is ignored.
- R6: A write that clears the enable drives the output to 0 from the clock after the write, in the middle of a period if need be. While disabled, the prescaler and the period counter stay at zero.
- R7: A synchronous active-high reset clears the configuration word to zero. The output reads 0 on the clock after reset.
- R8: Any write zeroes the prescaler and the period counter. The new setting starts a fresh period on the clock after the write, and the old period is not completed.
- R9: After the enable is set, counting starts from zero. With a nonzero duty, the output is 1 on the first clock after the enabling write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgWrite | input | 1 | One-cycle strobe that loads cfgData |
| cfgData | input | 32 | Configuration word (layout in R1) |
| pwmOut | output | 1 | Modulated output, active high |

## Verification
The bench targets the following corner cases, and each wrong design fails in a visible way:
- **Divisor off by one.** A design that divides by the field value instead of value+1 gets a period of the wrong length when the divisor is 2. It also stalls when the divisor is 0.
- **Duty compare with `<=` instead of `<`.** The output glitches high when duty is 0, and a duty of 64 gives 65 high ticks.
- **Rewrite restart.** A word is rewritten in the middle of a period and the output is sampled 150 clocks later. A design that keeps counting from the old position reads low there, where a restarted period still reads high.
- **Disable and ignored bits.** Disabling in the middle of a period must drop the output on the next clock. Setting the unused bits must leave the high-time count unchanged.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
  localparam int DIV_W     = 13;
  localparam int CNT_W     = 8;
  localparam int WORD_W    = 32;
  localparam int DIV_LSB   = 0;
  localparam int DUTY_LSB  = 16;
  localparam int FULL_BIT  = 24;
  localparam int EN_BIT    = 31;
  localparam int PERIOD_TICKS = 1 << CNT_W;

  typedef struct packed {
    logic             enable;
    logic             fullDuty;
    logic [CNT_W-1:0] duty;
    logic [DIV_W-1:0] divisor;
  } pwm_cfg_t;

  typedef struct packed {
    logic clear;
    logic tick;
  } pwm_strobe_t;

  function automatic pwm_cfg_t decodeCfg(input logic [WORD_W-1:0] w);
    pwm_cfg_t c;
    c.enable   = w[EN_BIT];
    c.fullDuty = w[FULL_BIT];
    c.duty     = w[DUTY_LSB +: CNT_W];
    c.divisor  = w[DIV_LSB +: DIV_W];
    return c;
  endfunction
endpackage

// File: rtl/pwm_gen_ctrl.sv
module pwm_gen_ctrl
  import pwm_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWrite,
  input  logic [WORD_W-1:0] cfgData,
  output pwm_cfg_t          cfg,
  output pwm_strobe_t       strb
);
  pwm_cfg_t         cfgQ;
  logic [DIV_W-1:0] prescQ;
  logic             clearNow;
  logic             tickNow;

  always_ff @(posedge clk) begin
    if (rst)           cfgQ <= '0;
    else if (cfgWrite) cfgQ <= decodeCfg(cfgData);
  end

  // Restart on any write; hold while disabled.
  assign clearNow = cfgWrite || !cfgQ.enable;
  assign tickNow  = cfgQ.enable && (prescQ == cfgQ.divisor);

  always_ff @(posedge clk) begin
    if (rst || clearNow)  prescQ <= '0;
    else if (tickNow)     prescQ <= '0;
    else                  prescQ <= prescQ + 1'b1;
  end

  assign cfg        = cfgQ;
  assign strb.clear = clearNow;
  assign strb.tick  = tickNow;

  p_presc_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cfgQ.enable |-> prescQ <= cfgQ.divisor);
  p_hold_disabled_r6: assert property (@(posedge clk) disable iff (rst)
    !cfgQ.enable |=> prescQ == '0);
  p_write_clears_r8: assert property (@(posedge clk) disable iff (rst)
    cfgWrite |=> prescQ == '0);
endmodule

// File: rtl/pwm_gen_dp.sv
module pwm_gen_dp
  import pwm_gen_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  pwm_cfg_t    cfg,
  input  pwm_strobe_t strb,
  output logic        pwmOut
);
  logic [CNT_W-1:0] periodCnt;
  logic             belowDuty;

  always_ff @(posedge clk) begin
    if (rst || strb.clear) periodCnt <= '0;
    else if (strb.tick)    periodCnt <= periodCnt + 1'b1;
  end

  assign belowDuty = periodCnt < cfg.duty;
  assign pwmOut    = cfg.enable && (cfg.fullDuty || belowDuty);

  p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
    strb.clear |=> periodCnt == '0);
  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    (strb.tick && !strb.clear) |=> periodCnt == CNT_W'($past(periodCnt) + 1'b1));
  p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!strb.tick && !strb.clear) |=> $stable(periodCnt));
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_gen_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cfgWrite,
  input  logic [31:0] cfgData,
  output logic        pwmOut
);
  pwm_cfg_t    cfg;
  pwm_strobe_t strb;

  pwm_gen_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cfgWrite(cfgWrite), .cfgData(cfgData),
    .cfg(cfg), .strb(strb)
  );

  pwm_gen_dp u_dp (
    .clk(clk), .rst(rst), .cfg(cfg), .strb(strb), .pwmOut(pwmOut)
  );

  p_reset_low_r7: assert property (@(posedge clk) rst |=> !pwmOut);
  p_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
    (!cfgWrite && !cfg.enable) |=> !pwmOut);
endmodule

// File: tb/pwm_gen_tb.sv
`timescale 1ns/1ps
module pwm_gen_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        cfgWrite = 0;
  logic [31:0] cfgData = '0;
  logic        pwmOut;

  int errors = 0;
  int checks = 0;
  bit started = 0;
  bit done = 0;
  string phaseTag = "R7";

  // reference model state
  int mEn = 0, mFull = 0, mDuty = 0, mDiv = 0, mPsc = 0, mCnt = 0;

  always #2 clk = ~clk;

  pwm_gen u_dut (.clk(clk), .rst(rst), .cfgWrite(cfgWrite), .cfgData(cfgData), .pwmOut(pwmOut));

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      mEn = 0; mFull = 0; mDuty = 0; mDiv = 0; mPsc = 0; mCnt = 0;
    end else if (cfgWrite) begin
      mEn = cfgData[31]; mFull = cfgData[24];
      mDuty = cfgData[23:16]; mDiv = cfgData[12:0];
      mPsc = 0; mCnt = 0;
    end else if (!mEn) begin
      mPsc = 0; mCnt = 0;
    end else if (mPsc == mDiv) begin
      mPsc = 0; mCnt = (mCnt + 1) % 256;
    end else begin
      mPsc = mPsc + 1;
    end
  end

  function automatic bit expOut();
    return (mEn != 0) && ((mFull != 0) || (mCnt < mDuty));
  endfunction

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (pwmOut !== expOut()) begin
        errors++;
        $display("FAIL %s model compare t=%0t actual=%b expected=%b", phaseTag, $time, pwmOut, expOut());
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeCfg(logic [31:0] w);
    @(negedge clk);
    cfgData = w; cfgWrite = 1;
    @(negedge clk);
    cfgWrite = 0;
  endtask

  task automatic countHigh(int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwmOut === 1'b1) highs++;
    end
  endtask

  function automatic logic [31:0] mk(bit en, bit full, int duty, int dv);
    return {en, 6'b0, full, 8'(duty), 3'b0, 13'(dv)};
  endfunction

  initial begin : main
    int h;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R7", pwmOut, 0);
    countHigh(20, h); check("R7", h, 0);

    phaseTag = "R3";
    writeCfg(mk(1, 0, 64, 0));
    check("R9", pwmOut, 1);
    countHigh(256, h); check("R3", h, 64);

    phaseTag = "R2";
    writeCfg(mk(1, 0, 10, 2));
    countHigh(768, h); check("R2", h, 30);
    writeCfg(mk(1, 0, 1, 0));
    countHigh(512, h); check("R2", h, 2);

    phaseTag = "R4";
    writeCfg(mk(1, 0, 0, 0));
    check("R4", pwmOut, 0);
    countHigh(300, h); check("R4", h, 0);

    phaseTag = "R5";
    writeCfg(mk(1, 1, 0, 1));
    countHigh(600, h); check("R5", h, 600);
    writeCfg(mk(1, 1, 3, 0));
    countHigh(300, h); check("R5", h, 300);

    phaseTag = "R1";
    writeCfg(mk(1, 0, 128, 0) | 32'h7E00_E000);
    countHigh(256, h); check("R1", h, 128);

    phaseTag = "R8";
    writeCfg(mk(1, 0, 200, 0));
    repeat (99) @(negedge clk);
    writeCfg(mk(1, 0, 200, 0));
    check("R8", pwmOut, 1);
    repeat (150) @(negedge clk);
    check("R8", pwmOut, 1);

    phaseTag = "R6";
    repeat (20) @(negedge clk);
    writeCfg(mk(0, 1, 200, 0));
    check("R6", pwmOut, 0);
    countHigh(50, h); check("R6", h, 0);

    phaseTag = "R9";
    writeCfg(mk(1, 0, 5, 3));
    check("R9", pwmOut, 1);
    countHigh(1024, h); check("R9", h, 20);

    phaseTag = "R7";
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R7", pwmOut, 0);
    countHigh(30, h); check("R7", h, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule